// File: doc/BRIEF.md
# Dual-Channel Serial Reset Controller

This block holds the single shared interrupt-control and reset-command register of a two-channel serial controller. Either channel's register port can write it. Each write carries a two-bit command in its top bits. The command can do nothing, reset channel A, reset channel B, or force a full reset that behaves like the external reset. The low bits carry the interrupt-control settings, and they are loaded by the same write.

A channel reset is reported in two forms. The first is a one-cycle clear pulse, which clears that channel's pending and in-service interrupt flags and its interrupt enables. The second is a held quiet level, which keeps the receiver and transmitter off, the transmit line marking and the modem outputs high. The quiet level stays until that channel is rearmed.

Every active reset starts a four-cycle write lockout. A write that hits a locked path is dropped and raises a sticky error flag. In multiplexed bus mode the lockout covers only the reset channel's path. In non-multiplexed mode it covers both paths.

Top module: `serial_reset_ctrl`

## Requirements
- R1: After the external active-low reset, the following hold: `ctl_q` = 0, `shift_dir` = 0, `chan_quiet` = 2'b11, `chan_clr` = 0, `hw_rst` = 0, `lock_busy` = 0 and `err_flag` = 0.
- R2: An accepted write through either path loads data bits 4:0 into `ctl_q` bits 4:0 at the clock edge that samples it. Bit 0 is vector-includes-status, bit 1 no-vector, bit 2 disable-lower-chain, bit 3 master-interrupt-enable and bit 4 status-high/low. `ctl_q` bits 7:5 always read 0, whatever bit 5 of the data is. Without an accepted write, `ctl_q` holds.
- R3: Command 2'b00 in data bits 7:6 produces no clear pulse, no `hw_rst`, no change of `chan_quiet` and no lockout.
- R4: Command 2'b10 pulses `chan_clr[0]` (channel A) for exactly the one cycle after the write edge. Command 2'b01 does the same for `chan_clr[1]` (channel B). The targeted `chan_quiet` bit is 1 from that same cycle on.
- R5: Once set, a `chan_quiet` bit stays 1 until a `chan_rearm` pulse on that channel clears it. A reset of that channel in the same cycle as the rearm wins, and the bit stays 1.
- R6: Command 2'b11 pulses both `chan_clr` bits and `hw_rst` for one cycle and sets both quiet bits. It clears `ctl_q` bits 1:0 but loads bits 4:2 from the data. It leaves `shift_dir` unchanged.
- R7: After an active reset write at edge N, a write through the reset channel's path at edges N+1 to N+4 is ignored. At N+5 it is accepted. In multiplexed mode (`bus_demux` = 0) the other path is not locked.
- R8: With `bus_demux` = 1, an active reset locks both paths for the same four edges.
- R9: A write strobe on a locked path sets `err_flag`, and the flag stays set until the external reset. Accepted writes never set it.
- R10: `shift_dir` loads `shift_dir_in` when `shift_dir_ld` is high, and only the external reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External active-low reset |
| bus_demux | input | 1 | 1: non-multiplexed bus, lockout covers both paths |
| wr_en_a | input | 1 | Write strobe through channel A's register port |
| wr_en_b | input | 1 | Write strobe through channel B's register port |
| wr_data | input | 8 | Write data: bits 7:6 command, bit 5 unused, bits 4:0 control |
| shift_dir_ld | input | 1 | Load strobe for the shift-direction bit |
| shift_dir_in | input | 1 | New shift-direction value |
| chan_rearm | input | 2 | Per-channel release of the quiet level (bit 0 = A) |
| ctl_q | output | 8 | Register contents, bits 7:5 read 0 |
| shift_dir | output | 1 | Shift-direction bit |
| chan_clr | output | 2 | One-cycle interrupt clear pulse per channel |
| chan_quiet | output | 2 | Held level: rx/tx off, line marking, modem high |
| hw_rst | output | 1 | One-cycle pulse for the forced full reset |
| lock_busy | output | 2 | Lockout window running per channel |
| err_flag | output | 1 | Sticky flag for a write dropped by lockout |

## Verification
The hardest case to reach from the ports is the edge of the lockout window. A write must land exactly on the last blocked edge or on the first free one, and it must come through the path that the mode does or does not lock. The bench issues each reset kind (A, B and null) and places a marker write 1 to 6 edges after it. It does this through both paths and in both bus modes. From the command that was accepted or dropped, it predicts `ctl_q` and `err_flag`. A full sweep of all 256 data values on both paths covers the command decode and the masking of the forced reset.

// File: rtl/serial_reset_pkg.sv
package serial_reset_pkg;
  localparam int NCH  = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int CTL_W = 5;

  typedef enum logic [1:0] {
    CMD_NULL  = 2'b00,
    CMD_RST_B = 2'b01,
    CMD_RST_A = 2'b10,
    CMD_FORCE = 2'b11
  } rcmd_e;

  // Channel targets of a command: index 0 = A, index 1 = B.
  function automatic logic [NCH-1:0] cmd_targets(input rcmd_e c);
    logic [NCH-1:0] t;
    t[CH_A] = c[1];
    t[CH_B] = c[0];
    return t;
  endfunction

  // New control bits after an accepted write; forced reset zeroes VIS/NV.
  function automatic logic [CTL_W-1:0] next_ctl(input logic [7:0] d);
    logic [CTL_W-1:0] v;
    v = d[CTL_W-1:0];
    if (d[7:6] == CMD_FORCE) v[1:0] = 2'b00;
    return v;
  endfunction
endpackage

// File: rtl/serial_reset_cmd_dec.sv
module serial_reset_cmd_dec
  import serial_reset_pkg::*;
(
  input  logic           wr_ok,
  input  logic [7:0]     wr_data,
  output logic [NCH-1:0] hit,
  output logic           force_rst,
  output logic [CTL_W-1:0] ctl_next
);
  rcmd_e cmd;
  assign cmd       = rcmd_e'(wr_data[7:6]);
  assign hit       = wr_ok ? cmd_targets(cmd) : '0;
  assign force_rst = wr_ok && (cmd == CMD_FORCE);
  assign ctl_next  = next_ctl(wr_data);
endmodule

// File: rtl/serial_reset_lockout.sv
module serial_reset_lockout #(
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(LOCK_CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
  assign busy = (cnt != '0);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LOCK_CYCLES));
  assert_start_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/serial_reset_chan_fx.sv
module serial_reset_chan_fx (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rearm,
  output logic clr_pulse,
  output logic quiet
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_pulse <= 1'b0;
      quiet     <= 1'b1;
    end else begin
      clr_pulse <= hit;
      if (hit)        quiet <= 1'b1;
      else if (rearm) quiet <= 1'b0;
    end
  end

  assert_pulse_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> quiet);
  assert_release_by_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quiet) |-> $past(rearm));
endmodule

// File: rtl/serial_reset_ctrl.sv
module serial_reset_ctrl
  import serial_reset_pkg::*;
#(
  parameter int LOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_demux,
  input  logic       wr_en_a,
  input  logic       wr_en_b,
  input  logic [7:0] wr_data,
  input  logic       shift_dir_ld,
  input  logic       shift_dir_in,
  input  logic [1:0] chan_rearm,
  output logic [7:0] ctl_q,
  output logic       shift_dir,
  output logic [1:0] chan_clr,
  output logic [1:0] chan_quiet,
  output logic       hw_rst,
  output logic [1:0] lock_busy,
  output logic       err_flag
);
  logic [NCH-1:0]   busy;
  logic [NCH-1:0]   lock_path;
  logic [NCH-1:0]   strobe;
  logic [NCH-1:0]   hit;
  logic             wr_ok;
  logic             wr_rej;
  logic             force_rst;
  logic [CTL_W-1:0] ctl_next;
  logic [CTL_W-1:0] ctl_r;
  logic             sdir_r;
  logic             err_r;
  logic             hw_r;

  assign strobe = {wr_en_b, wr_en_a};

  // Path gating: demuxed bus locks every path while any window runs.
  assign lock_path = bus_demux ? {NCH{|busy}} : busy;
  assign wr_ok  = |(strobe & ~lock_path);
  assign wr_rej = |(strobe & lock_path);

  serial_reset_cmd_dec u_dec (
    .wr_ok    (wr_ok),
    .wr_data  (wr_data),
    .hit      (hit),
    .force_rst(force_rst),
    .ctl_next (ctl_next)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    serial_reset_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk  (clk),
      .rst_n(rst_n),
      .start(hit[g]),
      .busy (busy[g])
    );
    serial_reset_chan_fx u_fx (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit[g]),
      .rearm    (chan_rearm[g]),
      .clr_pulse(chan_clr[g]),
      .quiet    (chan_quiet[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r  <= '0;
      sdir_r <= 1'b0;
      err_r  <= 1'b0;
      hw_r   <= 1'b0;
    end else begin
      if (wr_ok)        ctl_r  <= ctl_next;
      if (shift_dir_ld) sdir_r <= shift_dir_in;
      if (wr_rej)       err_r  <= 1'b1;
      hw_r <= force_rst;
    end
  end

  assign ctl_q     = {{(8-CTL_W){1'b0}}, ctl_r};
  assign shift_dir = sdir_r;
  assign err_flag  = err_r;
  assign hw_rst    = hw_r;
  assign lock_busy = busy;

  assert_clr_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_clr) |-> $past(wr_ok));
  assert_force_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |-> (&chan_clr));
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(ctl_r));
  assert_locked_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(strobe & lock_path)) |=> err_flag);
  assert_demux_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_demux && (|busy)) |=> $stable(ctl_r));
  assert_sdir_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_dir_ld |=> $stable(sdir_r));
endmodule

// File: tb/serial_reset_ctrl_bench.sv
module serial_reset_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_demux = 1'b0;
  logic       wr_en_a = 1'b0, wr_en_b = 1'b0;
  logic [7:0] wr_data = '0;
  logic       shift_dir_ld = 1'b0, shift_dir_in = 1'b0;
  logic [1:0] chan_rearm = '0;
  logic [7:0] ctl_q;
  logic       shift_dir, hw_rst, err_flag;
  logic [1:0] chan_clr, chan_quiet, lock_busy;

  int compared = 0;
  int mismatched = 0;

  serial_reset_ctrl u_serial_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_demux(bus_demux),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
    .shift_dir_ld(shift_dir_ld), .shift_dir_in(shift_dir_in),
    .chan_rearm(chan_rearm), .ctl_q(ctl_q), .shift_dir(shift_dir),
    .chan_clr(chan_clr), .chan_quiet(chan_quiet), .hw_rst(hw_rst),
    .lock_busy(lock_busy), .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctl(input logic [7:0] d);
    return (d[7:6] == 2'b11) ? (d & 8'h1C) : (d & 8'h1F);
  endfunction

  // Strobe sampled at the next rising edge; returns at the following negedge.
  task automatic do_write(input int path, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en_a = (path == 0);
    wr_en_b = (path == 1);
    @(negedge clk);
    wr_en_a = 1'b0;
    wr_en_b = 1'b0;
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic err_model;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctl", ctl_q, 0);
    check("R1 sdir", shift_dir, 0);
    check("R1 quiet", chan_quiet, 2'b11);
    check("R1 clr", chan_clr, 0);
    check("R1 hw", hw_rst, 0);
    check("R1 busy", lock_busy, 0);
    check("R1 err", err_flag, 0);

    // R10 load shift direction
    @(negedge clk); shift_dir_ld = 1'b1; shift_dir_in = 1'b1;
    @(negedge clk); shift_dir_ld = 1'b0;
    check("R10 sdir load", shift_dir, 1);

    // Release quiet levels
    chan_rearm = 2'b11; @(negedge clk); chan_rearm = 2'b00;
    check("R5 rearm release", chan_quiet, 2'b00);

    // Sweep all data values on both paths (R2 R3 R4 R6)
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] dv;
        logic [1:0] hits;
        dv = 8'(d);
        hits = {dv[6], dv[7]};
        do_write(p, dv);
        check("R2 ctl load", ctl_q, exp_ctl(dv));
        check("R4 clr pulse", chan_clr, hits);
        check("R6 hw pulse", hw_rst, dv[7:6] == 2'b11);
        check("R4 quiet set", chan_quiet, hits);
        check("R3 lock start", lock_busy, hits);
        check("R6 sdir kept", shift_dir, 1);
        @(negedge clk);
        check("R4 pulse width", {hw_rst, chan_clr}, 0);
        check("R5 quiet held", chan_quiet, hits);
        chan_rearm = 2'b11; @(negedge clk); chan_rearm = 2'b00;
        check("R5 rearm", chan_quiet, 0);
        repeat (3) @(negedge clk);
      end
    end
    check("R9 no err on accepted", err_flag, 0);

    // R5 reset wins over rearm in the same cycle
    @(negedge clk);
    wr_data = 8'h80; wr_en_a = 1'b1; chan_rearm = 2'b01;
    @(negedge clk);
    wr_en_a = 1'b0; chan_rearm = 2'b00;
    check("R5 reset beats rearm", chan_quiet, 2'b01);
    repeat (6) @(negedge clk);

    // Lockout window sweep (R3 R7 R8 R9)
    err_model = 1'b0;
    for (int m = 0; m < 2; m++) begin
      bus_demux = m[0];
      for (int rc = 0; rc < 3; rc++) begin
        for (int wp = 0; wp < 2; wp++) begin
          for (int k = 1; k <= 6; k++) begin
            logic [7:0] cmd;
            logic locked;
            cmd = (rc == 0) ? 8'h80 : (rc == 1) ? 8'h40 : 8'h00;
            locked = (rc != 2) && (k <= 4) && (m == 1 || wp == rc);
            do_write((rc == 2) ? 0 : rc, cmd);
            check("R3 ctl after cmd", ctl_q, 0);
            repeat (k - 1) @(negedge clk);
            wr_data = 8'h0B;
            wr_en_a = (wp == 0);
            wr_en_b = (wp == 1);
            @(negedge clk);
            wr_en_a = 1'b0; wr_en_b = 1'b0;
            err_model = err_model | locked;
            if (m == 1) check("R8 demux lock", ctl_q, locked ? 8'h00 : 8'h0B);
            else        check("R7 path lock", ctl_q, locked ? 8'h00 : 8'h0B);
            check("R9 err sticky", err_flag, err_model);
            repeat (6) @(negedge clk);
          end
        end
      end
    end

    // R9 / R10 external reset clears flag and shift direction
    hard_reset();
    @(negedge clk);
    check("R9 err cleared", err_flag, 0);
    check("R10 sdir cleared", shift_dir, 0);
    check("R1 quiet after reset", chan_quiet, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule